// File: doc/BRIEF.md
# Frequency Comparator with Hysteresis

This block compares the rates of two periodic pulse trains, a reference and a feedback signal, with logic clocked only by the system clock. Both inputs are asynchronous. Each passes through a two-stage synchronizer and a rising-edge detector, which turns every input edge into a single pulse one clock wide. A counter per input measures the period as the number of system clocks between successive pulses. The counter saturates at all ones, so a stalled or very slow input shows up as the largest period rather than as a wrapped small one.

A small control FSM waits until both counters have delivered a fresh period since the previous result. It then compares the two and issues a one-cycle result strobe. With the strobe come a signed difference (feedback period minus reference period) and a two-bit relation code: reference faster, reference slower, or equal. The equal decision uses two thresholds. The block enters the equal state at a tight inner band and leaves it only beyond a wider outer band. Near-equal frequencies therefore do not make the flag chatter. Downstream control logic can use the signed difference to anticipate how quickly the loop is converging.

Top module: `freq_cmp_hyst`

## Requirements
- R1: Each rising edge of `ref_i` or `fb_i` passes a two-flip-flop synchronizer and becomes exactly one internal pulse one clock wide.
- R2: A measured period is the number of clock cycles between two consecutive edge pulses of the same input. The period counter saturates at 2^CNT_W-1 and does not wrap.
- R3: `valid_o` is high for exactly one cycle, and only after both inputs have each delivered a new period since the previous result.
- R4: On a result, `diff_o` equals the feedback period minus the reference period, as a signed CNT_W+1-bit value.
- R5: `rel_o` is 2'b01 when the reference is faster (`diff_o` > 0), 2'b10 when it is slower (`diff_o` < 0), and 2'b00 when in the equal state. The value 2'b11 never appears.
- R6: When not in the equal state, a result with |diff| <= INNER enters the equal state. A result with |diff| > INNER stays unequal.
- R7: In the equal state, results with |diff| <= OUTER keep it equal. A result with |diff| > OUTER leaves it.
- R8: `rel_o` and `diff_o` hold their values between result strobes.
- R9: An active-low asynchronous reset clears the counters, the FSM and the hysteresis state. It also drives `valid_o`=0, `rel_o`=2'b00 and `diff_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference pulse train, asynchronous |
| fb_i | input | 1 | Feedback pulse train, asynchronous |
| valid_o | output | 1 | One-cycle result strobe |
| rel_o | output | 2 | Relation code: 01 reference faster, 10 slower, 00 equal |
| diff_o | output | CNT_W+1 | Signed feedback period minus reference period |

## Verification
The hardest case to reach from the ports is a hysteresis decision that depends on history: a difference that lies between the inner and outer thresholds must give different relation codes depending on whether the block arrived from the equal state or from far away. The stimulus holds the reference period fixed and walks the feedback period one clock at a time up through the band, down through it to the other side, and back again. Each crossing of the band is therefore made from both directions. A second case that is hard to reach is counter saturation. It is produced by stalling the feedback input for longer than the counter range and then restarting it, which yields one result carrying the saturated period.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [1:0] {
    REL_EQ   = 2'b00,
    REL_FAST = 2'b01,
    REL_SLOW = 2'b10
  } rel_e;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_CMP  = 1'b1
  } st_e;
endpackage

// File: rtl/fcmp_edge_sync.sv
module fcmp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic pulse_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its delayed copy
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh      <= '0;
      pulse_o <= 1'b0;
    end else begin
      sh      <= {sh[STAGES-1:0], sig_i};
      pulse_o <= sh[STAGES-1] & ~sh[STAGES];
    end
  end
endmodule

// File: rtl/fcmp_period_cnt.sv
module fcmp_period_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] period_o,
  output logic             new_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt      <= '0;
      armed    <= 1'b0;
      period_o <= '0;
      new_o    <= 1'b0;
    end else begin
      new_o <= 1'b0;
      if (pulse_i) begin
        cnt   <= CNT_ONE;
        armed <= 1'b1;
        // first edge after reset only starts the measurement
        if (armed) begin
          period_o <= cnt;
          new_o    <= 1'b1;
        end
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + CNT_ONE;
      end
    end
  end
endmodule

// File: rtl/fcmp_hyst.sv
module fcmp_hyst #(
  parameter int CNT_W = 16,
  parameter int INNER = 2,
  parameter int OUTER = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic signed [CNT_W:0] diff_i,
  output logic              eq_nx_o
);
  logic              eq_q;
  logic [CNT_W:0]    mag;

  always_comb begin
    mag     = diff_i[CNT_W] ? CNT_W'(0) - diff_i : diff_i;
    eq_nx_o = eq_q ? (int'(mag) <= OUTER) : (int'(mag) <= INNER);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    eq_q <= 1'b0;
    else if (upd_i) eq_q <= eq_nx_o;
  end
endmodule

// File: rtl/freq_cmp_hyst.sv
module freq_cmp_hyst
  import fcmp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int INNER       = 2,
  parameter int OUTER       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ref_i,
  input  logic                  fb_i,
  output logic                  valid_o,
  output logic [1:0]            rel_o,
  output logic signed [CNT_W:0] diff_o
);
  logic             ref_pls, fb_pls;
  logic [CNT_W-1:0] ref_per, fb_per;
  logic             ref_new, fb_new;
  logic             ref_rdy, fb_rdy;
  logic             eq_nx;
  logic signed [CNT_W:0] diff;
  st_e              st;

  fcmp_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(ref_i), .pulse_o(ref_pls));
  fcmp_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(fb_i), .pulse_o(fb_pls));

  fcmp_period_cnt #(.CNT_W(CNT_W)) u_ref_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(ref_pls),
    .period_o(ref_per), .new_o(ref_new));
  fcmp_period_cnt #(.CNT_W(CNT_W)) u_fb_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(fb_pls),
    .period_o(fb_per), .new_o(fb_new));

  assign diff = $signed({1'b0, fb_per}) - $signed({1'b0, ref_per});

  fcmp_hyst #(.CNT_W(CNT_W), .INNER(INNER), .OUTER(OUTER)) u_hyst (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(st == ST_CMP),
    .diff_i(diff), .eq_nx_o(eq_nx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_WAIT;
      ref_rdy <= 1'b0;
      fb_rdy  <= 1'b0;
      valid_o <= 1'b0;
      rel_o   <= REL_EQ;
      diff_o  <= '0;
    end else begin
      // a period arriving during compare is kept for the next round
      ref_rdy <= ref_new | (ref_rdy & (st != ST_CMP));
      fb_rdy  <= fb_new  | (fb_rdy  & (st != ST_CMP));
      valid_o <= (st == ST_CMP);
      case (st)
        ST_WAIT: if (ref_rdy && fb_rdy) st <= ST_CMP;
        default: begin
          st     <= ST_WAIT;
          diff_o <= diff;
          if (eq_nx)         rel_o <= REL_EQ;
          else if (diff > 0) rel_o <= REL_FAST;
          else               rel_o <= REL_SLOW;
        end
      endcase
    end
  end
endmodule

// File: rtl/fcmp_chk.sv
module fcmp_chk #(
  parameter int CNT_W = 16,
  parameter int INNER = 2,
  parameter int OUTER = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ref_pls_i,
  input logic                  fb_pls_i,
  input logic                  valid_i,
  input logic [1:0]            rel_i,
  input logic signed [CNT_W:0] diff_i
);
  logic        prev_eq;
  logic [CNT_W:0] mag;
  assign mag = diff_i[CNT_W] ? CNT_W'(0) - diff_i : diff_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_eq <= 1'b0;
    else if (valid_i) prev_eq <= (rel_i == 2'b00);
  end

  // R1
  ref_pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pls_i |=> !ref_pls_i);
  // R1
  fb_pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pls_i |=> !fb_pls_i);
  // R3
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);
  // R5
  rel_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i != 2'b11);
  // R5
  rel_fast_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rel_i == 2'b01) |-> diff_i > 0);
  // R5
  rel_slow_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rel_i == 2'b10) |-> diff_i < 0);
  // R6
  enter_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && int'(mag) <= INNER) |-> rel_i == 2'b00);
  // R6
  stay_neq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !prev_eq && int'(mag) > INNER) |-> rel_i != 2'b00);
  // R7
  hold_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prev_eq && int'(mag) <= OUTER) |-> rel_i == 2'b00);
  // R7
  leave_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && int'(mag) > OUTER) |-> rel_i != 2'b00);
  // R8
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ($stable(rel_i) && $stable(diff_i)));
endmodule

bind freq_cmp_hyst fcmp_chk #(.CNT_W(CNT_W), .INNER(INNER), .OUTER(OUTER)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_pls_i(ref_pls), .fb_pls_i(fb_pls),
  .valid_i(valid_o), .rel_i(rel_o), .diff_i(diff_o));

// File: tb/tb_freq_cmp_hyst.sv
module tb_freq_cmp_hyst;
  localparam int CNT_W = 8;
  localparam int INNER = 2;
  localparam int OUTER = 6;
  localparam int REF_P = 20;
  localparam int SAT   = (1 << CNT_W) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0, ref_i = 1'b0, fb_i = 1'b0;
  logic valid_o;
  logic [1:0] rel_o;
  logic signed [CNT_W:0] diff_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int fb_per = REF_P;
  bit fb_dead = 1'b0, run = 1'b0, sat_seen = 1'b0;
  int chg_id = 0, seen_id = 0, since = 0;
  bit model_eq = 1'b0;

  freq_cmp_hyst #(.CNT_W(CNT_W), .INNER(INNER), .OUTER(OUTER)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .fb_i(fb_i),
    .valid_o(valid_o), .rel_o(rel_o), .diff_o(diff_o));

  always #2.5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    @(negedge clk_i);
    wait (run);
    forever begin
      ref_i = 1'b1; repeat (REF_P / 2) @(negedge clk_i);
      ref_i = 1'b0; repeat (REF_P - REF_P / 2) @(negedge clk_i);
    end
  end

  initial begin
    @(negedge clk_i);
    wait (run);
    forever begin
      if (fb_dead) begin
        fb_i = 1'b0; @(negedge clk_i);
      end else begin
        automatic int p = fb_per;
        fb_i = 1'b1; repeat (p / 2) @(negedge clk_i);
        fb_i = 1'b0; repeat (p - p / 2) @(negedge clk_i);
      end
    end
  end

  // result monitor: hysteresis model fed with the reported difference
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      if (chg_id != seen_id) begin seen_id = chg_id; since = 0; end
      if (rst_ni && valid_o) begin
        automatic int d = int'(diff_o);
        automatic int m = (d < 0) ? -d : d;
        automatic logic [1:0] er;
        model_eq = model_eq ? (m <= OUTER) : (m <= INNER);
        er = model_eq ? 2'b00 : ((d > 0) ? 2'b01 : 2'b10);
        check(rel_o == er, "R5 R6 R7 relation", int'(rel_o), int'(er));
        if (d == SAT - REF_P) sat_seen = 1'b1;
        since++;
        if (since >= 3 && !fb_dead && d != SAT - REF_P)
          check(d == fb_per - REF_P, "R1 R2 R4 difference", d, fb_per - REF_P);
        @(negedge clk_i);
        cyc++;
        check(valid_o == 1'b0, "R3 single strobe", int'(valid_o), 0);
      end
    end
  end

  initial begin
    wait (cyc > 150000);
    check(1'b0, "watchdog", cyc, 150000);
    finish_run();
  end

  task automatic step(input int p);
    fb_per = p;
    chg_id++;
    wait (since >= 5);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check(valid_o == 1'b0, "R9 valid reset", int'(valid_o), 0);
    check(rel_o == 2'b00, "R9 rel reset", int'(rel_o), 0);
    check(diff_o == '0, "R9 diff reset", int'(diff_o), 0);
    rst_ni = 1'b1;
    run = 1'b1;
    // R3: no result before both inputs give two edges
    repeat (10) @(negedge clk_i);
    check(valid_o == 1'b0, "R3 no early result", int'(valid_o), 0);
    for (int p = REF_P; p <= REF_P + 10; p++) step(p);
    for (int p = REF_P + 10; p >= REF_P - 10; p--) step(p);
    for (int p = REF_P - 10; p <= REF_P; p++) step(p);
    // R8: outputs hold between strobes
    wait (valid_o);
    @(negedge clk_i);
    begin
      automatic logic [1:0] r0 = rel_o;
      automatic int d0 = int'(diff_o);
      repeat (5) @(negedge clk_i);
      check(rel_o == r0 && int'(diff_o) == d0, "R8 hold", int'(diff_o), d0);
    end
    // R2 saturation: stall feedback beyond counter range
    fb_dead = 1'b1; chg_id++;
    repeat (SAT + 60) @(negedge clk_i);
    fb_dead = 1'b0;
    step(REF_P);
    check(sat_seen, "R2 saturated period", int'(sat_seen), 1);
    // R9 reset during operation
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(valid_o == 1'b0 && rel_o == 2'b00 && diff_o == '0, "R9 reset clears",
          int'(diff_o), 0);
    finish_run();
  end
endmodule